// File: doc/BRIEF.md
# Mask-Strobed Single-Word SDRAM Access Engine

This engine lets a slow host touch exactly one column of an already-open SDRAM row. It does not wait for the burst to reach the wanted column before starting it. It issues a burst command early, at the target column minus a host-supplied lead count. The data mask is held high so that no slot of the burst has any effect. Exactly `lead` cycles after the command, the burst address equals the target, and the mask drops for a single clock. Only that slot is stored (write) or driven back (read). For reads, the returned word is captured when it arrives, one CAS latency after the strobe, and is handed to the host.

Requests enter on a valid/ready channel. `req_ready` is high only while the engine is idle, so the host may hold `req_valid` for as long as it likes, and nothing is taken while an access is in flight. Read words leave on a valid/ready channel. The word and `rsp_valid` are held until the host raises `rsp_ready`, and the engine stays busy until then. Bank activation, refresh and burst termination are the surrounding controller's job. The mask stays high whenever the engine is not strobing, so a burst left running has no effect.

Top module: `mask_strobe_access`

## Requirements
- R1: The command is issued in the first cycle after a request is accepted. The command pins {cs_n, ras_n, cas_n, we_n} carry 0101 for read and 0100 for write, and 0111 (no-op) in every other cycle. `sd_ba` carries the request bank. `sd_addr` carries the start column, which is the target column minus the lead count.
- R2: `sd_dqm` is high from the command cycle until the strobe cycle. It is low for exactly one clock, exactly `lead` cycles after the command cycle (a lead of 0 strobes in the command cycle). It is high again in the following cycle.
- R3: For a write, `sd_dq_oe` is high and `sd_dq_out` holds the request data, unchanged, from the command cycle through the strobe cycle. Only the target column is altered; neighbouring columns keep their contents.
- R4: For a read, the word on `sd_dq_in` in the cycle CAS_LAT cycles after the strobe is captured. The captured word is presented on `rsp_rdata` with `rsp_valid` in the next cycle.
- R5: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold steady and `busy` stays high. The response completes on the first cycle in which both are high.
- R6: `req_ready` is high exactly when `busy` is low. `busy` rises in the cycle after a request is accepted. A request presented while busy is neither accepted nor carried out.
- R7: `done` is a one-cycle pulse. For a write it comes in the cycle after the strobe, when `busy` is already low. For a read it comes in the first cycle of `rsp_valid`.
- R8: When the lead count exceeds the target column, the start column wraps modulo the page length of 2^COL_W columns.
- R9: After reset, `busy`, `done`, `rsp_valid` and `sd_dq_oe` are low, `sd_dqm` is high, the command pins show the no-op, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (engine idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the open row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Word to store on a write |
| req_lead | input | COL_W | Cycles from command to mask strobe |
| rsp_valid | output | 1 | Read word available |
| rsp_ready | input | 1 | Host takes the read word |
| rsp_rdata | output | DATA_W | Captured read word |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | COL_W | Burst start column |
| sd_dqm | output | 1 | Data mask, high blocks the slot |
| sd_dq_out | output | DATA_W | Write data to the pins |
| sd_dq_oe | output | 1 | Data pin drive enable |
| sd_dq_in | input | DATA_W | Read data from the pins |

## Verification
The hardest situation to reach is proving that only the single unmasked slot has any effect. The bench therefore models the SDRAM with a running burst address. Masked read slots return a poison value, and masked write slots store nothing. A wrong strobe position then shows up as a wrong word read back, or as a changed neighbour column. Reaching the wrap and ignore cases needs targeted stimulus. Leads larger than the target column (including target 0) exercise the modulo start address. A long lead keeps the engine busy while a second, conflicting write is held on the request channel; that column is later read back unchanged.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_READ  = 4'b0101;
  localparam logic [3:0] CMD_WRITE = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_HOLD,
    ST_WAITLAT,
    ST_RESP
  } ssa_state_e;

endpackage

// File: rtl/ssa_col_calc.sv
module ssa_col_calc #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] target_col,
  input  logic [COL_W-1:0] lead,
  output logic [COL_W-1:0] start_col
);
  // COL_W-bit subtraction wraps modulo the page length
  always_comb start_col = target_col - lead;
endmodule

// File: rtl/ssa_strobe_timer.sv
module ssa_strobe_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/ssa_rd_capture.sv
module ssa_rd_capture #(
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] dq_in,
  output logic              fire,
  output logic [DATA_W-1:0] data_q
);
  logic [CAS_LAT-1:0] stage_q;

  generate
    if (CAS_LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= launch;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[CAS_LAT-2:0], launch};
      end
    end
  endgenerate

  assign fire = stage_q[CAS_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    data_q <= '0;
    else if (fire) data_q <= dq_in;
  end
endmodule

// File: rtl/mask_strobe_access.sv
module mask_strobe_access
  import ssa_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int COL_W   = 10,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [COL_W-1:0]  req_lead,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [COL_W-1:0]  sd_addr,
  output logic              sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);

  ssa_state_e        state_q, state_d;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  start_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q;

  logic              accept;
  logic              in_burst;
  logic              tmr_zero;
  logic              strobe;
  logic              cap_fire;
  logic [COL_W-1:0]  start_col;
  logic [3:0]        cmd_bits;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_burst  = (state_q == ST_ISSUE) || (state_q == ST_HOLD);
  assign strobe    = in_burst && tmr_zero;

  ssa_col_calc #(.COL_W(COL_W)) col_calc_i (
    .target_col (req_col),
    .lead       (req_lead),
    .start_col  (start_col)
  );

  ssa_strobe_timer #(.CNT_W(COL_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (req_lead),
    .run      (in_burst),
    .at_zero  (tmr_zero)
  );

  ssa_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) capture_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (strobe && !wr_q),
    .dq_in  (sd_dq_in),
    .fire   (cap_fire),
    .data_q (rsp_rdata)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_ISSUE;
      ST_ISSUE,
      ST_HOLD:    if (strobe) state_d = wr_q ? ST_IDLE : ST_WAITLAT;
                  else        state_d = ST_HOLD;
      ST_WAITLAT: if (cap_fire) state_d = ST_RESP;
      ST_RESP:    if (rsp_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      bank_q  <= '0;
      start_q <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (strobe && wr_q) || cap_fire;
      if (accept) begin
        wr_q    <= req_write;
        bank_q  <= req_bank;
        start_q <= start_col;
        wdata_q <= req_wdata;
      end
    end
  end

  always_comb begin
    cmd_bits = CMD_NOP;
    if (state_q == ST_ISSUE) cmd_bits = wr_q ? CMD_WRITE : CMD_READ;
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_bits;
  assign sd_ba     = bank_q;
  assign sd_addr   = start_q;
  assign sd_dqm    = !strobe;
  assign sd_dq_oe  = wr_q && in_burst;
  assign sd_dq_out = wdata_q;
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign done      = done_q;

endmodule

// File: rtl/mask_strobe_access_chk.sv
module mask_strobe_access_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              busy,
  input logic              done,
  input logic              sd_cas_n,
  input logic              sd_dqm,
  input logic              sd_dq_oe,
  input logic [DATA_W-1:0] sd_dq_out
);

  // R2
  mask_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_dqm |=> sd_dqm);

  // R1
  single_command_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cas_n |=> sd_cas_n);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);

  // R5
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R3
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe && $past(sd_dq_oe) |-> $stable(sd_dq_out));

  // R9
  idle_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sd_dqm && !sd_dq_oe);

endmodule

bind mask_strobe_access mask_strobe_access_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .busy      (busy),
  .done      (done),
  .sd_cas_n  (sd_cas_n),
  .sd_dqm    (sd_dqm),
  .sd_dq_oe  (sd_dq_oe),
  .sd_dq_out (sd_dq_out)
);

// File: tb/mask_strobe_access_tb_top.sv
module mask_strobe_access_tb_top;
  localparam int BANK_W = 2;
  localparam int COL_W  = 10;
  localparam int DATA_W = 16;
  localparam int CL     = 2;
  localparam int NBANK  = 1 << BANK_W;
  localparam int PAGE   = 1 << COL_W;
  localparam logic [DATA_W-1:0] POISON = 16'hEEEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0, req_lead = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_rdata;
  logic busy, done;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [BANK_W-1:0] sd_ba;
  logic [COL_W-1:0]  sd_addr;
  logic [DATA_W-1:0] sd_dq_out;
  logic [DATA_W-1:0] sd_dq_in = POISON;

  always #2.5 clk = ~clk;

  mask_strobe_access #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_col(req_col), .req_wdata(req_wdata), .req_lead(req_lead),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  typedef struct {
    bit                wr;
    bit                wrap;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  start;
    logic [COL_W-1:0]  lead;
    logic [DATA_W-1:0] data;
  } cmd_t;

  cmd_t              cmd_q[$];
  logic [DATA_W-1:0] rd_q[$];
  logic [DATA_W-1:0] mem    [NBANK][PAGE];
  logic [DATA_W-1:0] shadow [NBANK][PAGE];
  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    for (int b = 0; b < NBANK; b++)
      for (int c = 0; c < PAGE; c++) begin
        mem[b][c]    = {b[1:0], c[9:0], 4'h5};
        shadow[b][c] = {b[1:0], c[9:0], 4'h5};
      end
  end

  // SDRAM page model: running burst column, mask gates each slot
  logic              burst_on = 1'b0, burst_wr = 1'b0;
  logic [BANK_W-1:0] burst_ba = '0;
  logic [COL_W-1:0]  burst_col = '0;
  logic [DATA_W-1:0] rpipe [CL+1];
  initial for (int i = 0; i <= CL; i++) rpipe[i] = POISON;

  always @(negedge clk) begin
    logic [DATA_W-1:0] slot;
    slot = POISON;
    if (rst_n) begin
      if (!sd_cs_n && sd_ras_n && !sd_cas_n) begin
        burst_on  = 1'b1;
        burst_wr  = !sd_we_n;
        burst_ba  = sd_ba;
        burst_col = sd_addr;
      end else if (burst_on) begin
        burst_col = burst_col + 1'b1;
      end
      if (burst_on && !sd_dqm) begin
        if (burst_wr) mem[burst_ba][burst_col] = sd_dq_oe ? sd_dq_out : POISON;
        else          slot = mem[burst_ba][burst_col];
      end
    end
    for (int i = CL; i > 0; i--) rpipe[i] = rpipe[i-1];
    rpipe[0] = slot;
    sd_dq_in = rpipe[CL];
  end

  // Monitor / scoreboard
  cmd_t   cur;
  bit     tracking = 0, hi_next = 0, done_pend = 0, prev_rv = 0;
  int     ofs = 0;
  longint strobe_cyc = 0;
  logic [DATA_W-1:0] exp_rd;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hi_next) begin
        chk(sd_dqm, "R2", "mask high after strobe", sd_dqm, 1);
        hi_next = 0;
      end
      if (done_pend) begin
        chk(done && !busy && req_ready, "R7", "write done pulse / idle",
            {done, busy, req_ready}, 3'b101);
        done_pend = 0;
      end
      if (!sd_cas_n) begin
        if (cmd_q.size() == 0) begin
          chk(0, "R6", "command without accepted request", 1, 0);
        end else begin
          cur = cmd_q.pop_front();
          chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == (cur.wr ? 4'b0100 : 4'b0101),
              "R1", "command code", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n},
              cur.wr ? 4'b0100 : 4'b0101);
          chk(sd_ba == cur.bank, "R1", "bank", sd_ba, cur.bank);
          if (cur.wrap) chk(sd_addr == cur.start, "R8", "wrapped start column", sd_addr, cur.start);
          else          chk(sd_addr == cur.start, "R1", "start column", sd_addr, cur.start);
          tracking = 1;
          ofs = 0;
        end
      end
      if (tracking) begin
        if (cur.wr)
          chk(sd_dq_oe && sd_dq_out == cur.data, "R3", "write data held",
              sd_dq_out, cur.data);
        if (!sd_dqm) begin
          chk(ofs == int'(cur.lead), "R2", "strobe offset", ofs, cur.lead);
          if (cur.wr) done_pend = 1;
          else        strobe_cyc = cyc;
          tracking = 0;
          hi_next = 1;
        end
        ofs++;
      end
      if (rsp_valid && !prev_rv) begin
        chk(done, "R7", "read done pulse", done, 1);
        chk(cyc == strobe_cyc + CL + 1, "R4", "read response cycle",
            32'(cyc - strobe_cyc), CL + 1);
      end
      if (rsp_valid && rsp_ready) begin
        if (rd_q.size() == 0) chk(0, "R4", "unexpected response", rsp_rdata, 0);
        else begin
          exp_rd = rd_q.pop_front();
          chk(rsp_rdata == exp_rd, "R4", "read word", rsp_rdata, exp_rd);
        end
      end
      prev_rv = rsp_valid;
    end
    cyc++;
  end

  task automatic issue(input bit wr, input int bank, input int col, input int lead,
                       input logic [DATA_W-1:0] data);
    cmd_t it;
    it.wr    = wr;
    it.bank  = BANK_W'(bank);
    it.lead  = COL_W'(lead);
    it.start = COL_W'(col - lead);
    it.wrap  = lead > col;
    it.data  = data;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bank = BANK_W'(bank);
    req_col = COL_W'(col); req_lead = COL_W'(lead); req_wdata = data;
    while (!req_ready) @(negedge clk);
    cmd_q.push_back(it);
    if (wr) shadow[bank][col] = data;
    else    rd_q.push_back(shadow[bank][col]);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || cmd_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    logic [DATA_W-1:0] held;
    int unsigned lcg;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !rsp_valid && !sd_dq_oe && sd_dqm && req_ready, "R9",
        "reset outputs", {busy, done, rsp_valid, sd_dq_oe, sd_dqm, req_ready}, 6'b000011);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R9", "reset no-op",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);

    // basic write / read, neighbours (R3, R4)
    issue(1, 1, 100, 5, 16'hA1B2); wait_idle();
    issue(0, 1, 100, 5, '0);       wait_idle();
    issue(0, 1, 101, 5, '0);       wait_idle();
    issue(0, 1, 99, 3, '0);        wait_idle();
    // lead of zero
    issue(1, 2, 7, 0, 16'h0F0F);   wait_idle();
    issue(0, 2, 7, 0, '0);         wait_idle();
    // wrap of start column (R8)
    issue(1, 3, 3, 10, 16'h3C3C);  wait_idle();
    issue(0, 3, 3, 12, '0);        wait_idle();
    issue(1, 0, 0, 1, 16'h5A5A);   wait_idle();
    issue(0, 0, 0, 700, '0);       wait_idle();
    issue(0, 0, 1023, 1023, '0);   wait_idle();

    // R6: request held while busy is not taken
    issue(0, 0, 200, 30, '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_bank = '0; req_col = 10'd300;
    req_lead = 10'd2; req_wdata = 16'h1234;
    repeat (10) begin
      @(negedge clk);
      chk(!req_ready && busy, "R6", "ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    wait_idle();
    issue(0, 0, 300, 2, '0);       wait_idle();

    // R5: response back-pressure
    rsp_ready = 1'b0;
    issue(0, 1, 100, 4, '0);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    repeat (6) begin
      @(negedge clk);
      chk(rsp_valid && busy && !req_ready && rsp_rdata == held, "R5",
          "response held", rsp_rdata, held);
    end
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    wait_idle();

    // mixed sweep
    lcg = 32'h1234_5678;
    for (int n = 0; n < 24; n++) begin
      int b, c, l;
      lcg = lcg * 1103515245 + 12345;
      b = int'(lcg[31:30]);
      c = int'(lcg[25:16]);
      l = int'(lcg[7:2]);
      issue(1, b, c, l, lcg[15:0] | 16'h0001); wait_idle();
      issue(0, b, c, (l + 7) % 64, '0);          wait_idle();
    end

    repeat (5) @(negedge clk);
    chk(cmd_q.size() == 0 && rd_q.size() == 0, "R1", "all commands seen",
        cmd_q.size() + rd_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule